// File: doc/BRIEF.md
# Cell Balancing Supervisor FSM

This block is the digital control core of a secondary protection supervisor for a stack of three to five series cells. It receives four already-digitized comparator flags per cell and a slow timebase tick. From these it decides when the pack needs balancing, drives one discharge-switch enable per cell, and raises an overcharge output.

The block moves between three states: normal, balancing and overcharge-balancing. Once balancing starts, it runs a repeating cycle. First comes an off window, in which all switches are open and the flags are watched. Then comes an on window, in which the switches chosen at the window boundary stay closed and the flags are not looked at. The overcharge state only changes the output flag. Discharge keeps cycling while it is asserted.

All delays and window lengths count ticks of a 1 ms timebase. The output polarity and drive form are fixed by parameters.

Top module: `cbs_top`

## Requirements
- R1: After reset the block is in the normal state. Every `sw_en_o` bit is 0 and the overcharge output sits at its inactive level.
- R2: Flags are evaluated only in cycles where `tick_i` is 1, and outputs change at that clock edge. The block leaves normal for balancing when, in DET_TICKS consecutive ticks, at least one active cell's balancing-detect flag is set. A tick with none set restarts the count.
- R3: In either balancing state the block runs an off window of OFF_TICKS ticks followed by an on window of ON_TICKS ticks, repeating. The cycle starts with an off window on entry from normal, and every switch is open during an off window.
- R4: On an off-window tick in the balancing state, if no active cell has its balancing-release flag set, the block returns to normal with all switches open.
- R5: On the last tick of an off window, `sw_en_o` bit i is set to the balancing-release flag of cell i (bit i of `bal_rel_i`). This pattern is held unchanged for the whole on window.
- R6: If at that moment every active cell has its balancing-release flag set, every switch stays open for that on window.
- R7: During an on window all flags are ignored. Neither the switches nor the state nor the overcharge output change, even for overcharge-detect flags.
- R8: In the balancing state, OV_TICKS consecutive off-window ticks with any active overcharge-detect flag move the block to overcharge-balancing and make the output active. The count restarts on a tick without the flag, and it is cleared when the off window ends.
- R9: On an off-window tick in overcharge-balancing, if no active cell has its overcharge-release flag set, the block returns to balancing and the output goes inactive. The window cycle continues without restarting.
- R10: The output level is the overcharge state when ACTIVE_HIGH=1, and its inverse otherwise.
  - Push-pull (OPEN_DRAIN=0): `co_o` carries the level and `co_oe_o` is 1.
  - Open-drain (OPEN_DRAIN=1): `co_o` is always 0 and `co_oe_o` is 1 exactly when the level is low.
- R11: Flag bits at cell index CELLS or above are treated as cleared, and the corresponding `sw_en_o` bits are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per timebase period (1 ms) |
| bal_det_i | input | MAX_CELLS | Per-cell flag: above balancing-detect level |
| bal_rel_i | input | MAX_CELLS | Per-cell flag: above balancing-release level |
| ov_det_i | input | MAX_CELLS | Per-cell flag: above overcharge-detect level |
| ov_rel_i | input | MAX_CELLS | Per-cell flag: above overcharge-release level |
| sw_en_o | output | MAX_CELLS | Discharge switch enable per cell |
| co_o | output | 1 | Overcharge output drive value |
| co_oe_o | output | 1 | Overcharge output drive enable |

## Verification
Three events can land on the same tick: the last tick of an off window, the one that completes the overcharge persistence count, and the latching of the switch pattern. Together they enter overcharge-balancing and open the on window at once.

The bench shapes a directed overcharge run so that its final counting tick coincides with the final off tick. It then checks, in the cycle after that edge, that the switch pattern and the active output appear together.

The random phase uses a tick-level model to judge the other coincidences as they arise, such as a release to normal on a tick that also carries overcharge flags.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic [1:0] {
    ST_NORM = 2'd0,
    ST_BAL  = 2'd1,
    ST_OVB  = 2'd2
  } cbs_state_t;

  typedef enum logic {
    PH_OFF = 1'b0,
    PH_ON  = 1'b1
  } cbs_phase_t;
endpackage

// File: rtl/cbs_flag_mask.sv
module cbs_flag_mask #(
  parameter int MAX_CELLS = 5,
  parameter int CELLS     = 5
) (
  input  logic [MAX_CELLS-1:0] bal_det_i,
  input  logic [MAX_CELLS-1:0] bal_rel_i,
  input  logic [MAX_CELLS-1:0] ov_det_i,
  input  logic [MAX_CELLS-1:0] ov_rel_i,
  output logic                 any_det_o,
  output logic                 any_rel_o,
  output logic                 all_rel_o,
  output logic                 any_ovd_o,
  output logic                 any_ovr_o,
  output logic [MAX_CELLS-1:0] rel_act_o
);
  logic [MAX_CELLS-1:0] act;

  // active-cell mask: cells at index CELLS and above read as cleared (R11)
  for (genvar i = 0; i < MAX_CELLS; i++) begin : g_act
    assign act[i] = (i < CELLS);
  end

  assign rel_act_o = bal_rel_i & act;
  assign any_det_o = |(bal_det_i & act);
  assign any_rel_o = |rel_act_o;
  assign all_rel_o = &(bal_rel_i | ~act);
  assign any_ovd_o = |(ov_det_i & act);
  assign any_ovr_o = |(ov_rel_i & act);
endmodule

// File: rtl/cbs_persist.sv
module cbs_persist #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic cond_i,
  output logic hit_o
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM   = W'(LIMIT);
  localparam logic [W-1:0] LIMM1 = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !cond_i) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q != LIM) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign hit_o = cond_i && tick_i && (cnt_q == LIMM1);

  // R2 / R8: persistence count never runs past its limit
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM);
endmodule

// File: rtl/cbs_co_drive.sv
module cbs_co_drive #(
  parameter bit ACTIVE_HIGH = 1'b1,
  parameter bit OPEN_DRAIN  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic alarm_i,
  output logic co_o,
  output logic co_oe_o
);
  logic level;
  assign level = ACTIVE_HIGH ? alarm_i : ~alarm_i;

  if (OPEN_DRAIN) begin : g_od
    always_ff @(posedge clk) begin
      if (rst) begin
        co_o    <= 1'b0;
        co_oe_o <= ~(ACTIVE_HIGH ? 1'b0 : 1'b1);
      end else begin
        co_o    <= 1'b0;
        co_oe_o <= ~level;
      end
    end
    // R10: an open-drain pin only ever pulls low
    p_od_low_r10: assert property (@(posedge clk) disable iff (rst)
      co_o == 1'b0);
  end else begin : g_pp
    always_ff @(posedge clk) begin
      if (rst) begin
        co_o    <= ACTIVE_HIGH ? 1'b0 : 1'b1;
        co_oe_o <= 1'b1;
      end else begin
        co_o    <= level;
        co_oe_o <= 1'b1;
      end
    end
    // R10: push-pull output is always driven
    p_pp_drive_r10: assert property (@(posedge clk) disable iff (rst)
      co_oe_o == 1'b1);
  end
endmodule

// File: rtl/cbs_top.sv
module cbs_top #(
  parameter int MAX_CELLS   = 5,
  parameter int CELLS       = 5,
  parameter int DET_TICKS   = 256,
  parameter int OFF_TICKS   = 1000,
  parameter int ON_TICKS    = 7200,
  parameter int OV_TICKS    = 256,
  parameter bit ACTIVE_HIGH = 1'b1,
  parameter bit OPEN_DRAIN  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  input  logic [MAX_CELLS-1:0] bal_det_i,
  input  logic [MAX_CELLS-1:0] bal_rel_i,
  input  logic [MAX_CELLS-1:0] ov_det_i,
  input  logic [MAX_CELLS-1:0] ov_rel_i,
  output logic [MAX_CELLS-1:0] sw_en_o,
  output logic                 co_o,
  output logic                 co_oe_o
);
  import cbs_pkg::*;

  localparam int WIN_MAX = (OFF_TICKS > ON_TICKS) ? OFF_TICKS : ON_TICKS;
  localparam int WW      = $clog2(WIN_MAX + 1);
  localparam logic [WW-1:0] OFF_LAST = WW'(OFF_TICKS - 1);
  localparam logic [WW-1:0] ON_LAST  = WW'(ON_TICKS - 1);

  cbs_state_t st_q, st_d;
  cbs_phase_t ph_q, ph_d;
  logic [WW-1:0]        win_q, win_d;
  logic [MAX_CELLS-1:0] sw_q, sw_d;

  logic any_det, any_rel, all_rel, any_ovd, any_ovr;
  logic [MAX_CELLS-1:0] rel_act;
  logic det_hit, ov_hit;

  cbs_flag_mask #(.MAX_CELLS(MAX_CELLS), .CELLS(CELLS)) u_mask (
    .bal_det_i(bal_det_i), .bal_rel_i(bal_rel_i),
    .ov_det_i(ov_det_i),   .ov_rel_i(ov_rel_i),
    .any_det_o(any_det),   .any_rel_o(any_rel), .all_rel_o(all_rel),
    .any_ovd_o(any_ovd),   .any_ovr_o(any_ovr), .rel_act_o(rel_act)
  );

  cbs_persist #(.LIMIT(DET_TICKS)) u_det (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .cond_i(any_det && st_q == ST_NORM), .hit_o(det_hit)
  );

  cbs_persist #(.LIMIT(OV_TICKS)) u_ov (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .cond_i(any_ovd && st_q == ST_BAL && ph_q == PH_OFF), .hit_o(ov_hit)
  );

  always_comb begin
    st_d  = st_q;
    ph_d  = ph_q;
    win_d = win_q;
    sw_d  = sw_q;
    if (tick_i) begin
      case (st_q)
        ST_NORM: begin
          if (det_hit) begin
            st_d  = ST_BAL;
            ph_d  = PH_OFF;
            win_d = '0;
            sw_d  = '0;
          end
        end
        default: begin
          if (ph_q == PH_OFF) begin
            if (st_q == ST_BAL && !any_rel) begin
              st_d  = ST_NORM;
              ph_d  = PH_OFF;
              win_d = '0;
              sw_d  = '0;
            end else begin
              if (st_q == ST_BAL && ov_hit)        st_d = ST_OVB;
              else if (st_q == ST_OVB && !any_ovr) st_d = ST_BAL;
              if (win_q == OFF_LAST) begin
                ph_d  = PH_ON;
                win_d = '0;
                sw_d  = all_rel ? '0 : rel_act;
              end else begin
                win_d = win_q + WW'(1);
              end
            end
          end else begin
            if (win_q == ON_LAST) begin
              ph_d  = PH_OFF;
              win_d = '0;
              sw_d  = '0;
            end else begin
              win_d = win_q + WW'(1);
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_NORM;
      ph_q  <= PH_OFF;
      win_q <= '0;
      sw_q  <= '0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      win_q <= win_d;
      sw_q  <= sw_d;
    end
  end

  cbs_co_drive #(.ACTIVE_HIGH(ACTIVE_HIGH), .OPEN_DRAIN(OPEN_DRAIN)) u_co (
    .clk(clk), .rst(rst), .alarm_i(st_d == ST_OVB),
    .co_o(co_o), .co_oe_o(co_oe_o)
  );

  assign sw_en_o = sw_q;

  // R1: no discharge in normal state
  p_norm_open_r1: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_NORM) |-> (sw_q == '0));
  // R3: all switches open in an off window
  p_off_open_r3: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_OFF) |-> (sw_q == '0));
  // R7: state frozen across an on window
  p_on_state_r7: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_ON) |=> $stable(st_q));
  // R5 / R7: switch pattern held until the window closes
  p_on_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_ON) |=> (ph_q == PH_OFF || $stable(sw_q)));
  // R8: overcharge entered only from an off-window tick
  p_ov_entry_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q == ST_OVB) |-> ($past(ph_q) == PH_OFF && $past(st_q) == ST_BAL));

  always_comb begin
    if (!rst) begin
      // R6: never every active cell discharging at once
      p_not_all_r6: assert (CELLS == 0 || !(&sw_q[CELLS-1:0]));
    end
  end

  for (genvar i = CELLS; i < MAX_CELLS; i++) begin : g_unused
    // R11: unused cells never get a switch
    p_unused_off_r11: assert property (@(posedge clk) disable iff (rst)
      sw_q[i] == 1'b0);
  end
endmodule

// File: tb/test_cbs_top.sv
`timescale 1ns/1ps
module test_cbs_top;
  localparam int MAXC = 5;
  localparam int CELLS = 4;
  localparam int DET = 4;
  localparam int OFF = 6;
  localparam int ON = 8;
  localparam int OV = 3;
  localparam logic [4:0] ACT = 5'b01111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [4:0] bdet = '0, brel = '0, odet = '0, orel = '0;
  logic [4:0] sw_a, sw_b;
  logic co_a, oe_a, co_b, oe_b;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // model state: st 0 normal, 1 balancing, 2 overcharge-balancing; ph 0 off, 1 on
  int m_st = 0, m_ph = 0, m_win = 0, m_det = 0, m_ov = 0;
  logic [4:0] m_sw = '0;

  always #5 clk = ~clk;

  cbs_top #(.MAX_CELLS(MAXC), .CELLS(CELLS), .DET_TICKS(DET), .OFF_TICKS(OFF),
            .ON_TICKS(ON), .OV_TICKS(OV), .ACTIVE_HIGH(1'b1), .OPEN_DRAIN(1'b0))
  i_cbs_top (
    .clk(clk), .rst(rst), .tick_i(tick), .bal_det_i(bdet), .bal_rel_i(brel),
    .ov_det_i(odet), .ov_rel_i(orel), .sw_en_o(sw_a), .co_o(co_a), .co_oe_o(oe_a));

  cbs_top #(.MAX_CELLS(MAXC), .CELLS(CELLS), .DET_TICKS(DET), .OFF_TICKS(OFF),
            .ON_TICKS(ON), .OV_TICKS(OV), .ACTIVE_HIGH(1'b0), .OPEN_DRAIN(1'b1))
  i_cbs_top_od (
    .clk(clk), .rst(rst), .tick_i(tick), .bal_det_i(bdet), .bal_rel_i(brel),
    .ov_det_i(odet), .ov_rel_i(orel), .sw_en_o(sw_b), .co_o(co_b), .co_oe_o(oe_b));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_sw_pattern(input logic [4:0] rel);
    logic [4:0] r;
    r = rel & ACT;
    return ((rel | ~ACT) == 5'h1f) ? 5'h00 : r;
  endfunction

  task automatic model_step(input logic [4:0] bu, input logic [4:0] bl,
                            input logic [4:0] cu, input logic [4:0] cl);
    logic [4:0] u, l, d, c;
    u = bu & ACT; l = bl & ACT; d = cu & ACT; c = cl & ACT;
    if (m_st == 0) begin
      if (|u) begin
        m_det++;
        if (m_det == DET) begin m_st = 1; m_ph = 0; m_win = 0; m_det = 0; end
      end else m_det = 0;
    end else if (m_ph == 0) begin
      if (m_st == 1 && !(|l)) begin
        m_st = 0; m_win = 0; m_sw = '0; m_ov = 0;
      end else begin
        if (m_st == 1) begin
          if (|d) begin
            m_ov++;
            if (m_ov == OV) begin m_st = 2; m_ov = 0; end
          end else m_ov = 0;
        end else if (!(|c)) m_st = 1;
        if (m_win == OFF - 1) begin
          m_ph = 1; m_win = 0; m_ov = 0; m_sw = exp_sw_pattern(bl);
        end else m_win++;
      end
    end else begin
      if (m_win == ON - 1) begin m_ph = 0; m_win = 0; m_sw = '0; end
      else m_win++;
    end
  endtask

  task automatic compare(input string tag);
    logic ovb;
    ovb = (m_st == 2);
    chk({tag, " sw"}, {3'b0, sw_a}, {3'b0, m_sw});
    chk({tag, " co push-pull"}, {6'b0, co_a, oe_a}, {6'b0, ovb, 1'b1});
    chk({"R10 open-drain ", tag}, {1'b0, sw_b, co_b, oe_b}, {1'b0, m_sw, 1'b0, ovb});
  endtask

  task automatic step(input logic [4:0] bu, input logic [4:0] bl,
                      input logic [4:0] cu, input logic [4:0] cl, input string tag);
    @(negedge clk);
    bdet = bu; brel = bl; odet = cu; orel = cl;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    model_step(bu, bl, cu, cl);
    compare(tag);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 sw", {3'b0, sw_a}, 8'h00);
    chk("R1 co", {6'b0, co_a, oe_a}, 8'h01);
    chk("R1 od", {6'b0, co_b, oe_b}, 8'h00);

    // R11: flags on the unused cell change nothing
    repeat (DET + 3) step(5'h10, 5'h13, 5'h10, 5'h10, "R11");
    repeat (OFF + 2) step(5'h00, 5'h13, 5'h00, 5'h00, "R11");

    // R2: broken run restarts the count, full run enters balancing
    repeat (DET - 1) step(5'h02, 5'h03, 5'h00, 5'h00, "R2");
    step(5'h00, 5'h03, 5'h00, 5'h00, "R2");
    repeat (DET) step(5'h02, 5'h03, 5'h00, 5'h00, "R2");

    // R3 off window, R5 pattern latch (unused bit 4 set too: R11)
    while (m_ph == 0 && m_win < OFF - 1) step(5'h00, 5'h15, 5'h00, 5'h00, "R3");
    step(5'h00, 5'h15, 5'h00, 5'h00, "R5");
    // R7: anything during on window is ignored
    while (m_ph == 1) step(5'($urandom), 5'($urandom), 5'h0f, 5'h0f, "R7");

    // R6: every active cell above release -> all open
    while (m_ph == 0 && m_win < OFF - 1) step(5'h00, 5'h0f, 5'h00, 5'h00, "R3");
    step(5'h00, 5'h0f, 5'h00, 5'h00, "R6");
    while (m_ph == 1) step(5'h00, 5'h00, 5'h0f, 5'h0f, "R7");

    // R8: broken run, then full run ending on the last off tick
    repeat (OV - 1) step(5'h00, 5'h06, 5'h04, 5'h04, "R8");
    step(5'h00, 5'h06, 5'h00, 5'h04, "R8");
    repeat (OV) step(5'h00, 5'h06, 5'h04, 5'h04, "R8");
    while (m_ph == 1) step(5'h00, 5'h06, 5'h04, 5'h04, "R8");

    // R9: release from overcharge, windows continue
    repeat (2) step(5'h00, 5'h06, 5'h04, 5'h04, "R9");
    step(5'h00, 5'h06, 5'h00, 5'h00, "R9");
    while (m_ph == 0 && m_win < OFF - 1) step(5'h00, 5'h06, 5'h00, 5'h00, "R9");
    step(5'h00, 5'h06, 5'h00, 5'h00, "R5");
    while (m_ph == 1) step(5'h00, 5'h00, 5'h00, 5'h00, "R7");

    // R4: all below release -> normal, stays there
    step(5'h00, 5'h00, 5'h00, 5'h00, "R4");
    repeat (OFF + ON) step(5'h00, 5'h0f, 5'h00, 5'h00, "R4");

    // constrained random mix
    for (int k = 0; k < 600; k++) begin
      logic [4:0] bu, bl, cu, cl;
      bu = ($urandom % 4 == 0) ? 5'($urandom) : 5'h00;
      bl = ($urandom % 5 == 0) ? 5'h00 : 5'($urandom);
      cu = ($urandom % 3 == 0) ? 5'($urandom) : 5'h00;
      cl = ($urandom % 4 == 0) ? 5'h00 : (cu | 5'($urandom));
      step(bu, bl, cu, cl, "R5/R8 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule